// File: doc/BRIEF.md
# Split Instruction/Data Address Translation Cache

This block holds two small direct-mapped translation caches, one serving instruction fetches and one serving data accesses. Each has a combinational lookup port. The port takes a virtual address and returns a hit flag. On a hit it also returns the physical address, formed from the cached page number and the untouched 12-bit page offset. Pages are 4 KB, so only address bits 31..12 take part in translation.

Software manages both caches through two control registers, and no separate control register exists.

The **virtual register** can be read and written. Bit 0 picks the target cache, and bits 2..1 carry a command that runs at the moment the register is written. The same register receives the faulting page address when an enabled lookup misses, so a miss handler finds the target already set up.

The **physical register** is laid out like a page-table entry. Writing it installs an entry at the page held in the virtual register, so a refill takes a single write. Reading it returns the matching cached entry.

A miss from either cache raises one shared pending indication. The indication stays up until software acknowledges it.

The fault recorder is a two-state machine:
- **FLT_IDLE** (no miss pending) moves to **FLT_PEND** on any enabled lookup miss. The *capture* transition also loads the fault address.
- **FLT_PEND** returns to **FLT_IDLE** on the acknowledge input (*release*).

Top module: `dual_xlate_buf`

## Requirements
- R1: A lookup hits when the entry at index VA[17:12] of its cache is valid and its stored tag equals VA[31:18]. On a hit the output address is {PPN, VA[11:0]}. On a miss the hit flag is 0 and the output address is 0. Both outputs are combinational.
- R2: The two caches are separate. Bit 0 of the virtual register (or of the value written to it) set to 1 selects the instruction cache, and set to 0 selects the data cache. An operation on one cache leaves the other unchanged.
- R3: Writing the physical register with {PPN[31:12], FLAGS[11:0]} installs a valid entry at the page held in the virtual register, in the cache chosen by its bit 0. Lookups see the entry from the next cycle.
- R4: Reading the physical register combinationally returns {PPN, FLAGS} of the selected cache's entry for the virtual register's page when that entry is valid and its tag matches, and 0 otherwise.
- R5: A write to the virtual register stores the written value, which reads back from the next cycle. Command field [2:1] values 00 and 11 only load the register and leave every entry unchanged.
- R6: Command 01 invalidates the indexed entry of the selected cache only when its tag matches the written address. An entry with a different tag at that index stays valid.
- R7: Command 10 invalidates every entry of the selected cache. Lookups miss from the next cycle.
- R8: An enabled lookup that misses while no miss is pending sets the pending output in the next cycle. In that same cycle the virtual register is loaded with {VA[31:12], 11'b0, bank}, where bank is 1 for the instruction port. A lookup with its enable low records nothing.
- R9: If both ports record a miss in the same cycle, the data address is recorded with bit 0 = 0.
- R10: While a miss is pending, further misses do not change the virtual register. Pending stays at 1 until the acknowledge input is high, and it reads 0 in the cycle after.
- R11: After reset, pending is 0, the virtual register reads 0, and every entry of both caches is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilook_va | input | 32 | Instruction lookup virtual address |
| ilook_en | input | 1 | Instruction lookup valid; a miss is recorded only when high |
| ilook_hit | output | 1 | Instruction lookup hit |
| ilook_pa | output | 32 | Instruction translated address (0 on miss) |
| dlook_va | input | 32 | Data lookup virtual address |
| dlook_en | input | 1 | Data lookup valid; a miss is recorded only when high |
| dlook_hit | output | 1 | Data lookup hit |
| dlook_pa | output | 32 | Data translated address (0 on miss) |
| csr_we_va | input | 1 | Write strobe for the virtual register |
| csr_we_pa | input | 1 | Write strobe for the physical register |
| csr_wdata | input | 32 | Write data for either register |
| csr_va | output | 32 | Virtual register contents |
| csr_pa | output | 32 | Physical register read value |
| miss_pend | output | 1 | Shared miss-pending indication |
| miss_ack | input | 1 | Acknowledge; clears the pending miss |

## Verification
Lookup results (R1) and the physical register read (R4) are combinational. The bench drives them on a falling edge and samples them one nanosecond later, within the same half-cycle. Register writes, commands and miss captures (R3, R5–R10) take effect on the next rising edge. Each of these stimuli is held for exactly one cycle between two falling edges, and the result is sampled at the second falling edge. Release after acknowledge is likewise checked one cycle after the acknowledge.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int unsigned XW    = 32;
    localparam int unsigned PG_W  = 12;
    localparam int unsigned IDX_W = 6;
    localparam int unsigned NENT  = 1 << IDX_W;
    localparam int unsigned TAG_W = XW - PG_W - IDX_W;
    localparam int unsigned PPN_W = XW - PG_W;
    localparam int unsigned NBANK = 2;

    typedef enum logic [1:0] {
        CMD_LOAD  = 2'b00,
        CMD_INVAL = 2'b01,
        CMD_FLUSH = 2'b10,
        CMD_RSVD  = 2'b11
    } va_cmd_e;

    typedef enum logic {
        FLT_IDLE = 1'b0,
        FLT_PEND = 1'b1
    } flt_state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        logic [PG_W-1:0]  flags;
    } xent_t;
endpackage

// File: rtl/xlate_bank.sv
module xlate_bank
    import xlate_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] lk_va,
    output logic          lk_hit,
    output logic [XW-1:0] lk_pa,
    input  logic [XW-1:0] rd_va,
    output logic [XW-1:0] rd_ent,
    input  logic          ins_en,
    input  logic [XW-1:0] ins_va,
    input  logic [XW-1:0] ins_pte,
    input  logic          cmd_en,
    input  logic [XW-1:0] cmd_va
);
    localparam int unsigned NPORT = 2;

    logic [NENT-1:0] vld_q;
    xent_t           mem_q [NENT];

    logic [XW-1:0]   p_va  [NPORT];
    logic            p_hit [NPORT];
    xent_t           p_ent [NPORT];

    assign p_va[0] = lk_va;
    assign p_va[1] = rd_va;

    // Both read ports use the same index/tag compare
    for (genvar p = 0; p < NPORT; p++) begin : g_rport
        logic [IDX_W-1:0] idx;
        assign idx      = p_va[p][PG_W +: IDX_W];
        assign p_ent[p] = mem_q[idx];
        assign p_hit[p] = vld_q[idx] && (mem_q[idx].tag == p_va[p][XW-1 -: TAG_W]);
    end

    assign lk_hit = p_hit[0];
    assign lk_pa  = p_hit[0] ? {p_ent[0].ppn, lk_va[PG_W-1:0]} : '0;
    assign rd_ent = p_hit[1] ? {p_ent[1].ppn, p_ent[1].flags} : '0;

    va_cmd_e          cmd;
    logic [IDX_W-1:0] cmd_idx;
    logic [IDX_W-1:0] ins_idx;
    logic             cmd_tag_ok;

    assign cmd        = va_cmd_e'(cmd_va[2:1]);
    assign cmd_idx    = cmd_va[PG_W +: IDX_W];
    assign ins_idx    = ins_va[PG_W +: IDX_W];
    assign cmd_tag_ok = mem_q[cmd_idx].tag == cmd_va[XW-1 -: TAG_W];

    // Valid bits: flush, then single invalidate, then install (last wins)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (cmd_en) begin
                unique case (cmd)
                    CMD_FLUSH: vld_q <= '0;
                    CMD_INVAL: if (cmd_tag_ok) vld_q[cmd_idx] <= 1'b0;
                    CMD_LOAD, CMD_RSVD: ;
                endcase
            end
            if (ins_en) vld_q[ins_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            mem_q[ins_idx] <= '{tag:   ins_va[XW-1 -: TAG_W],
                                ppn:   ins_pte[XW-1:PG_W],
                                flags: ins_pte[PG_W-1:0]};
        end
    end
endmodule

// File: rtl/xlate_fault_fsm.sv
module xlate_fault_fsm
    import xlate_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_miss,
    input  logic [XW-1:0] i_va,
    input  logic          d_miss,
    input  logic [XW-1:0] d_va,
    input  logic          sw_we,
    input  logic [XW-1:0] sw_data,
    input  logic          ack,
    output logic [XW-1:0] vaddr,
    output logic          pending
);
    flt_state_e state_q, state_d;
    logic       capture;
    logic [XW-1:0] flt_addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: capture (IDLE->PEND), release (PEND->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_IDLE: if (i_miss || d_miss) state_d = FLT_PEND;
            FLT_PEND: if (ack)              state_d = FLT_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pending  = (state_q == FLT_PEND);
        capture  = (state_q == FLT_IDLE) && (i_miss || d_miss);
        flt_addr = d_miss ? {d_va[XW-1:PG_W], {(PG_W-1){1'b0}}, 1'b0}
                          : {i_va[XW-1:PG_W], {(PG_W-1){1'b0}}, 1'b1};
    end

    // Shared virtual register: a capture takes precedence over a write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vaddr <= '0;
        else if (capture) vaddr <= flt_addr;
        else if (sw_we)   vaddr <= sw_data;
    end
endmodule

// File: rtl/dual_xlate_buf.sv
module dual_xlate_buf
    import xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ilook_va,
    input  logic        ilook_en,
    output logic        ilook_hit,
    output logic [31:0] ilook_pa,
    input  logic [31:0] dlook_va,
    input  logic        dlook_en,
    output logic        dlook_hit,
    output logic [31:0] dlook_pa,
    input  logic        csr_we_va,
    input  logic        csr_we_pa,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_va,
    output logic [31:0] csr_pa,
    output logic        miss_pend,
    input  logic        miss_ack
);
    // Bank 0 = data, bank 1 = instruction (matches select bit)
    logic [XW-1:0] b_lk_va  [NBANK];
    logic          b_hit    [NBANK];
    logic [XW-1:0] b_pa     [NBANK];
    logic [XW-1:0] b_rd     [NBANK];
    logic [XW-1:0] vaddr_q;

    assign b_lk_va[0] = dlook_va;
    assign b_lk_va[1] = ilook_va;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        xlate_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_va   (b_lk_va[b]),
            .lk_hit  (b_hit[b]),
            .lk_pa   (b_pa[b]),
            .rd_va   (vaddr_q),
            .rd_ent  (b_rd[b]),
            .ins_en  (csr_we_pa && (vaddr_q[0] == 1'(b))),
            .ins_va  (vaddr_q),
            .ins_pte (csr_wdata),
            .cmd_en  (csr_we_va && (csr_wdata[0] == 1'(b))),
            .cmd_va  (csr_wdata)
        );
    end

    xlate_fault_fsm u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_miss  (ilook_en && !b_hit[1]),
        .i_va    (ilook_va),
        .d_miss  (dlook_en && !b_hit[0]),
        .d_va    (dlook_va),
        .sw_we   (csr_we_va),
        .sw_data (csr_wdata),
        .ack     (miss_ack),
        .vaddr   (vaddr_q),
        .pending (miss_pend)
    );

    assign dlook_hit = b_hit[0];
    assign dlook_pa  = b_pa[0];
    assign ilook_hit = b_hit[1];
    assign ilook_pa  = b_pa[1];
    assign csr_va    = vaddr_q;
    assign csr_pa    = vaddr_q[0] ? b_rd[1] : b_rd[0];
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ilook_va,
    input logic        ilook_en,
    input logic        ilook_hit,
    input logic [31:0] ilook_pa,
    input logic [31:0] dlook_va,
    input logic        dlook_en,
    input logic        dlook_hit,
    input logic [31:0] dlook_pa,
    input logic        csr_we_va,
    input logic        csr_we_pa,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_va,
    input logic        miss_pend,
    input logic        miss_ack
);
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dlook_hit |-> dlook_pa[11:0] == dlook_va[11:0]);

    p_miss_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ilook_hit |-> ilook_pa == 32'h0);

    p_flush_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_va && csr_wdata[2:1] == 2'b10 && !csr_wdata[0] && !csr_we_pa)
        |=> !dlook_hit);

    p_dcapture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_pend && dlook_en && !dlook_hit) |=> (miss_pend && !csr_va[0]));

    p_icapture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_pend && ilook_en && !ilook_hit && !(dlook_en && !dlook_hit))
        |=> (miss_pend && csr_va[0]));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_pend && !miss_ack) |=> miss_pend);

    p_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_pend && !csr_we_va) |=> $stable(csr_va));

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_pend && miss_ack) |=> !miss_pend);
endmodule

bind dual_xlate_buf xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ilook_va  (ilook_va),
    .ilook_en  (ilook_en),
    .ilook_hit (ilook_hit),
    .ilook_pa  (ilook_pa),
    .dlook_va  (dlook_va),
    .dlook_en  (dlook_en),
    .dlook_hit (dlook_hit),
    .dlook_pa  (dlook_pa),
    .csr_we_va (csr_we_va),
    .csr_we_pa (csr_we_pa),
    .csr_wdata (csr_wdata),
    .csr_va    (csr_va),
    .miss_pend (miss_pend),
    .miss_ack  (miss_ack)
);

// File: tb/sim_dual_xlate_buf.sv
`timescale 1ns/1ps
module sim_dual_xlate_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ilook_va = '0, dlook_va = '0, csr_wdata = '0;
    logic        ilook_en = 1'b0, dlook_en = 1'b0;
    logic        csr_we_va = 1'b0, csr_we_pa = 1'b0, miss_ack = 1'b0;
    logic        ilook_hit, dlook_hit, miss_pend;
    logic [31:0] ilook_pa, dlook_pa, csr_va, csr_pa;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_xlate_buf u0 (.*);

    typedef struct packed {
        logic        sel;
        logic [31:0] va;
        logic        hit;
        logic [31:0] pa;
    } vec_t;

    // sel: 1 = instruction port, 0 = data port
    localparam vec_t VECS [6] = '{
        '{1'b0, 32'h0040_1234, 1'b1, 32'h1234_5234},
        '{1'b0, 32'h8000_3FFC, 1'b1, 32'hABCD_EFFC},
        '{1'b0, 32'h0044_1000, 1'b0, 32'h0000_0000},
        '{1'b0, 32'h0040_2000, 1'b0, 32'h0000_0000},
        '{1'b1, 32'h0040_1ABC, 1'b1, 32'h5555_5ABC},
        '{1'b1, 32'h8000_3000, 1'b0, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_va(input logic [31:0] d);
        @(negedge clk); csr_we_va = 1'b1; csr_wdata = d;
        @(negedge clk); csr_we_va = 1'b0;
    endtask

    task automatic wr_pa(input logic [31:0] d);
        @(negedge clk); csr_we_pa = 1'b1; csr_wdata = d;
        @(negedge clk); csr_we_pa = 1'b0;
    endtask

    task automatic look(input logic sel, input logic [31:0] va);
        @(negedge clk);
        if (sel) ilook_va = va; else dlook_va = va;
        #1;
    endtask

    task automatic miss_cycle(input logic ien, input logic [31:0] iva,
                              input logic den, input logic [31:0] dva);
        @(negedge clk);
        ilook_va = iva; dlook_va = dva; ilook_en = ien; dlook_en = den;
        @(negedge clk);
        ilook_en = 1'b0; dlook_en = 1'b0;
    endtask

    task automatic ack_cycle();
        @(negedge clk); miss_ack = 1'b1;
        @(negedge clk); miss_ack = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 pending", 32'(miss_pend), 32'h0);
        chk("R11 vaddr", csr_va, 32'h0);
        chk("R11 paddr read", csr_pa, 32'h0);
        rst_n = 1'b1;
        look(1'b0, 32'h0040_1000);
        chk("R11 data invalid", 32'(dlook_hit), 32'h0);
        look(1'b1, 32'h0040_1000);
        chk("R11 instr invalid", 32'(ilook_hit), 32'h0);

        // R3/R5: installs (cmd 00 loads address only)
        wr_va(32'h0040_1000); chk("R5 readback", csr_va, 32'h0040_1000);
        wr_pa(32'h1234_50A5);
        wr_va(32'h8000_3000); wr_pa(32'hABCD_E003);
        wr_va(32'h0040_1001); wr_pa(32'h5555_50FF);

        // R1/R2/R3: table of lookups
        for (int k = 0; k < 6; k++) begin
            look(VECS[k].sel, VECS[k].va);
            chk("R1 hit", 32'(VECS[k].sel ? ilook_hit : dlook_hit), 32'(VECS[k].hit));
            chk("R1 pa",  VECS[k].sel ? ilook_pa : dlook_pa, VECS[k].pa);
        end

        // R4: physical register read
        #1 chk("R4 instr entry", csr_pa, 32'h5555_50FF);
        wr_va(32'h0040_1000); #1 chk("R4 data entry", csr_pa, 32'h1234_50A5);
        wr_va(32'h0044_1000); #1 chk("R4 tag mismatch", csr_pa, 32'h0);
        // R5: cmd 11 is a no-op
        wr_va(32'h0040_1006); #1 chk("R5 cmd11 keeps entry", csr_pa, 32'h1234_50A5);
        chk("R5 cmd11 readback", csr_va, 32'h0040_1006);

        // R8: disabled lookup miss records nothing
        miss_cycle(1'b0, 32'h0, 1'b0, 32'h0060_0ABC);
        chk("R8 no enable", 32'(miss_pend), 32'h0);
        // R8: data capture
        miss_cycle(1'b0, 32'h0, 1'b1, 32'h0060_0ABC);
        chk("R8 data pending", 32'(miss_pend), 32'h1);
        chk("R8 data vaddr", csr_va, 32'h0060_0000);
        // R10: pending blocks further capture
        miss_cycle(1'b1, 32'h0070_0000, 1'b0, 32'h0);
        chk("R10 vaddr held", csr_va, 32'h0060_0000);
        chk("R10 still pending", 32'(miss_pend), 32'h1);
        ack_cycle();
        chk("R10 released", 32'(miss_pend), 32'h0);

        // R9: both miss together
        miss_cycle(1'b1, 32'h0090_0000, 1'b1, 32'h00A0_0000);
        chk("R9 data wins", csr_va, 32'h00A0_0000);
        ack_cycle();

        // R8/R3: instruction capture then single-write refill
        miss_cycle(1'b1, 32'h00B0_5000, 1'b0, 32'h0);
        chk("R8 instr vaddr", csr_va, 32'h00B0_5001);
        wr_pa(32'h7777_7001);
        look(1'b1, 32'h00B0_5123);
        chk("R3 refill pa", ilook_pa, 32'h7777_7123);
        ack_cycle();

        // R6: invalidate (cmd 01, bits[2:1]) data entry
        wr_va(32'h0040_1002);
        look(1'b0, 32'h0040_1234); chk("R6 data invalidated", 32'(dlook_hit), 32'h0);
        look(1'b1, 32'h0040_1234); chk("R2 instr unaffected", ilook_pa, 32'h5555_5234);
        wr_va(32'h0044_3002);
        look(1'b0, 32'h8000_3000); chk("R6 tag mismatch kept", dlook_pa, 32'hABCD_E000);

        // R7: flush instruction cache (cmd 10, bit0=1)
        wr_va(32'h0000_0005);
        look(1'b1, 32'h0040_1000); chk("R7 instr flushed", 32'(ilook_hit), 32'h0);
        look(1'b1, 32'h00B0_5000); chk("R7 instr flushed 2", 32'(ilook_hit), 32'h0);
        look(1'b0, 32'h8000_3000); chk("R2 data survives flush", 32'(dlook_hit), 32'h1);
        wr_va(32'h0000_0004);
        look(1'b0, 32'h8000_3000); chk("R7 data flushed", 32'(dlook_hit), 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule